// File: doc/BRIEF.md
# Renamed Floating-Point Control Word

This block holds up to four in-flight copies of the floating-point control word, so that a program that changes its rounding mode does not have to drain the pipeline first. One copy is always the committed one. The others are speculative copies, each made by a control-word write that has not yet retired. The copies sit in a circular set of slots. A write takes the next slot and receives that slot's tag. Every younger operation reads the newest tag at dispatch, carries it, and later presents it on an execution read port to get the rounding mode it must use.

Retirement of a control-word write makes its copy the committed one and frees the copy before it. A flush throws away every speculative copy and makes the committed copy the newest again. A write arriving while all four slots are live is held off with a stall until a retire frees a slot. A typical use is switching to truncation before a float-to-integer conversion and back to nearest-even after it.

Top module: `fpcw_rename`

## Requirements
- R1: After reset exactly one version is live in tag 0. That version is both newest and committed, its value is the reset control word 16'h037F, and its rounding field reads 00.
- R2: A write that is accepted (wr_valid high, wr_stall low, flush low) is reported on wr_tag during the same cycle. From the next cycle, cur_tag equals that tag and cur_cw equals the written value.
- R3: Up to four versions can be live. When four are live, wr_valid raises wr_stall in the same cycle. A stalled write leaves cur_tag and cur_cw unchanged.
- R4: Each execution read port returns bits 11:10 of the version selected by its tag in the same cycle. The encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 truncate. Writing a newer version does not alter an older one.
- R5: rt_valid with more than one version live advances cmt_tag by one in circular order on the next cycle and frees one slot.
- R6: rt_valid with only one version live is ignored. cmt_tag, cur_tag and the stall condition are unchanged.
- R7: On flush, from the next cycle cur_tag equals cmt_tag and cur_cw equals the committed value. A retire in the same cycle is applied first. A write in the same cycle is dropped.
- R8: When a retire and a write arrive in the same cycle while four versions are live, the write still stalls. The retire takes effect.
- R9: Tags are handed out in the circular order 0,1,2,3,0, and freed tags are reused in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Control-word write request |
| wr_cw | input | 16 | New control-word value |
| wr_stall | output | 1 | Write held off, all versions live |
| wr_tag | output | 2 | Tag the pending write receives |
| rt_valid | input | 1 | Oldest speculative write has retired |
| flush | input | 1 | Discard all speculative versions |
| cur_tag | output | 2 | Tag of newest version, for dispatch |
| cur_cw | output | 16 | Value of newest version |
| cmt_tag | output | 2 | Tag of committed version |
| ex_tag | input | 4 | Two packed tags from execution units |
| ex_rc | output | 4 | Two packed 2-bit rounding modes |

## Verification
A wrong pointer or count shows up at the ports within one cycle. It appears as a cur_tag or cmt_tag off the circular sequence, as wr_stall rising at three live versions or missing at four, or as a flush landing on a tag other than the committed one. A corrupted or wrongly indexed slot shows up on the very next execution read of that tag, as a rounding mode differing from the value last written to it. Random mixes of writes, retires and flushes run the ring through many wrap-arounds, so that an off-by-one at the wrap point is observed on cur_tag within a few dozen cycles.

// File: rtl/fpcw_pkg.sv
// Package: shared constants and the rounding-mode encoding for the
// renamed control word. Assumes the rounding field is two bits wide.
package fpcw_pkg;

    localparam int RC_W = 2;

    typedef enum logic [RC_W-1:0] {
        RC_NEAREST = 2'b00,
        RC_DOWN    = 2'b01,
        RC_UP      = 2'b10,
        RC_TRUNC   = 2'b11
    } rc_mode_e;

endpackage

// File: rtl/fpcw_ring_ctrl.sv
// Module: circular allocator for control-word versions.
// Tracks the committed slot (head), the newest slot (tail) and the live
// count. Assumes at least one version is always live.
module fpcw_ring_ctrl #(
    parameter int NUM_VER = 4,
    parameter int TAG_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req_i,
    input  logic             rt_req_i,
    input  logic             flush_i,
    output logic             wr_ok_o,
    output logic             stall_o,
    output logic [TAG_W-1:0] head_o,
    output logic [TAG_W-1:0] tail_o,
    output logic [TAG_W-1:0] next_tag_o
);

    logic [TAG_W-1:0] head_q, tail_q, head_nxt;
    logic [CNT_W-1:0] count_q;
    logic             full, ret_ok;

    function automatic logic [TAG_W-1:0] step_tag(input logic [TAG_W-1:0] t);
        return (t == TAG_W'(NUM_VER - 1)) ? '0 : t + 1'b1;
    endfunction

    // Decode request acceptance from occupancy.
    always_comb begin
        full       = (count_q == CNT_W'(NUM_VER));
        ret_ok     = rt_req_i && (count_q > CNT_W'(1));
        wr_ok_o    = wr_req_i && !full && !flush_i;
        stall_o    = wr_req_i && full;
        head_nxt   = ret_ok ? step_tag(head_q) : head_q;
        next_tag_o = step_tag(tail_q);
    end

    // Advance pointers and count; flush collapses to the committed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CNT_W'(1);
        end else begin
            head_q <= head_nxt;
            if (flush_i) begin
                tail_q  <= head_nxt;
                count_q <= CNT_W'(1);
            end else begin
                if (wr_ok_o) tail_q <= next_tag_o;
                case ({wr_ok_o, ret_ok})
                    2'b10:   count_q <= count_q + CNT_W'(1);
                    2'b01:   count_q <= count_q - CNT_W'(1);
                    default: count_q <= count_q;
                endcase
            end
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q >= CNT_W'(1)) && (count_q <= CNT_W'(NUM_VER)));

    assert_single_retire_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req_i && count_q == CNT_W'(1)) |=> $stable(head_q));

    assert_retire_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req_i && count_q > CNT_W'(1)) |=> (head_q != $past(head_q)));

    assert_full_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && full && !flush_i) |=> $stable(tail_q));

endmodule

// File: rtl/fpcw_version_store.sv
// Module: storage slots for control-word versions.
// One slot is written per cycle at most. The newest value is read out, and
// the rounding field of every slot is exposed. Assumes NUM_VER is 2**TAG_W.
module fpcw_version_store
    import fpcw_pkg::*;
#(
    parameter int          NUM_VER  = 4,
    parameter int          TAG_W    = 2,
    parameter int          CW_W     = 16,
    parameter int          RC_LSB   = 10,
    parameter logic [15:0] RESET_CW = 16'h037F
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [TAG_W-1:0]               wr_idx_i,
    input  logic [CW_W-1:0]                wr_cw_i,
    input  logic [TAG_W-1:0]               rd_idx_i,
    output logic [CW_W-1:0]                rd_cw_o,
    output logic [NUM_VER-1:0][RC_W-1:0]   rc_all_o
);

    logic [NUM_VER-1:0][CW_W-1:0] slot_q;

    // Write the selected slot; every slot starts at the reset value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_VER; i++) begin
            if (!rst_n)
                slot_q[i] <= CW_W'(RESET_CW);
            else if (we_i && (wr_idx_i == TAG_W'(i)))
                slot_q[i] <= wr_cw_i;
        end
    end

    // Read out the newest slot.
    assign rd_cw_o = slot_q[rd_idx_i];

    for (genvar g = 0; g < NUM_VER; g++) begin : g_rc
        assign rc_all_o[g] = slot_q[g][RC_LSB +: RC_W];

        assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (wr_idx_i == TAG_W'(g))) |=> $stable(slot_q[g]));
    end

endmodule

// File: rtl/fpcw_rc_read.sv
// Module: rounding-mode lookup ports for execution units.
// Each port selects one slot's rounding field by tag, without a register.
// Assumes tags presented are in range.
module fpcw_rc_read
    import fpcw_pkg::*;
#(
    parameter int NUM_VER = 4,
    parameter int TAG_W   = 2,
    parameter int NUM_RD  = 2
) (
    input  logic [NUM_VER-1:0][RC_W-1:0] rc_all_i,
    input  logic [NUM_RD*TAG_W-1:0]      ex_tag_i,
    output logic [NUM_RD*RC_W-1:0]       ex_rc_o
);

    for (genvar r = 0; r < NUM_RD; r++) begin : g_port
        // Select this port's slot.
        assign ex_rc_o[r*RC_W +: RC_W] = rc_all_i[ex_tag_i[r*TAG_W +: TAG_W]];
    end

endmodule

// File: rtl/fpcw_rename.sv
// Module: top of the renamed floating-point control word.
// Joins the allocator, slot storage and rounding read ports. Assumes the
// issuing logic retires control-word writes in order, one per rt_valid.
module fpcw_rename
    import fpcw_pkg::*;
#(
    parameter int          NUM_VER  = 4,
    parameter int          CW_W     = 16,
    parameter int          RC_LSB   = 10,
    parameter int          NUM_RD   = 2,
    parameter logic [15:0] RESET_CW = 16'h037F,
    localparam int         TAG_W    = $clog2(NUM_VER),
    localparam int         CNT_W    = $clog2(NUM_VER + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [CW_W-1:0]          wr_cw,
    output logic                     wr_stall,
    output logic [TAG_W-1:0]         wr_tag,
    input  logic                     rt_valid,
    input  logic                     flush,
    output logic [TAG_W-1:0]         cur_tag,
    output logic [CW_W-1:0]          cur_cw,
    output logic [TAG_W-1:0]         cmt_tag,
    input  logic [NUM_RD*TAG_W-1:0]  ex_tag,
    output logic [NUM_RD*RC_W-1:0]   ex_rc
);

    logic                         wr_ok;
    logic [NUM_VER-1:0][RC_W-1:0] rc_all;

    fpcw_ring_ctrl #(
        .NUM_VER(NUM_VER), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_req_i(wr_valid), .rt_req_i(rt_valid), .flush_i(flush),
        .wr_ok_o(wr_ok), .stall_o(wr_stall),
        .head_o(cmt_tag), .tail_o(cur_tag), .next_tag_o(wr_tag)
    );

    fpcw_version_store #(
        .NUM_VER(NUM_VER), .TAG_W(TAG_W), .CW_W(CW_W),
        .RC_LSB(RC_LSB), .RESET_CW(RESET_CW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(wr_ok), .wr_idx_i(wr_tag), .wr_cw_i(wr_cw),
        .rd_idx_i(cur_tag), .rd_cw_o(cur_cw), .rc_all_o(rc_all)
    );

    fpcw_rc_read #(
        .NUM_VER(NUM_VER), .TAG_W(TAG_W), .NUM_RD(NUM_RD)
    ) u_rd (
        .rc_all_i(rc_all), .ex_tag_i(ex_tag), .ex_rc_o(ex_rc)
    );

    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_stall && !flush) |=>
            (cur_cw == $past(wr_cw)) && (cur_tag == $past(wr_tag)));

    assert_stall_holds_newest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !flush) |=> (cur_tag == $past(cur_tag)));

    assert_flush_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cur_tag == cmt_tag));

endmodule

// File: tb/fpcw_rename_tb.sv
`timescale 1ns/1ps
module fpcw_rename_tb;
    import fpcw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, rt_valid, flush;
    logic [15:0] wr_cw;
    logic        wr_stall;
    logic [1:0]  wr_tag, cur_tag, cmt_tag;
    logic [15:0] cur_cw;
    logic [3:0]  ex_tag, ex_rc;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_cw [4];
    logic [1:0]  m_head, m_tail;
    int          m_cnt;

    always #5 clk = ~clk;

    fpcw_rename u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cw(wr_cw),
        .wr_stall(wr_stall), .wr_tag(wr_tag), .rt_valid(rt_valid),
        .flush(flush), .cur_tag(cur_tag), .cur_cw(cur_cw),
        .cmt_tag(cmt_tag), .ex_tag(ex_tag), .ex_rc(ex_rc)
    );

    function automatic logic [1:0] nxt(input logic [1:0] t);
        return t + 2'd1;
    endfunction

    function automatic logic [1:0] exp_rc(input logic [1:0] t);
        return m_cw[t][11:10];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: check registered state, drive, check same-cycle outputs, update model.
    task automatic step(input string req, input logic w, input logic [15:0] cw,
                        input logic r, input logic f, input logic [1:0] t0, input logic [1:0] t1);
        logic acc, ret;
        @(negedge clk);
        check({req, " cur_tag"}, 16'(cur_tag), 16'(m_tail));
        check({req, " cur_cw"},  cur_cw, m_cw[m_tail]);
        check({req, " cmt_tag R5"}, 16'(cmt_tag), 16'(m_head));
        wr_valid = w; wr_cw = cw; rt_valid = r; flush = f; ex_tag = {t1, t0};
        #1;
        check("R3 wr_stall", 16'(wr_stall), 16'(w && m_cnt == 4));
        if (w && m_cnt < 4) check("R9 wr_tag", 16'(wr_tag), 16'(nxt(m_tail)));
        check("R4 ex_rc port0", 16'(ex_rc[1:0]), 16'(exp_rc(t0)));
        check("R4 ex_rc port1", 16'(ex_rc[3:2]), 16'(exp_rc(t1)));
        @(posedge clk);
        acc = w && m_cnt < 4 && !f;
        ret = r && m_cnt > 1;
        if (ret) m_head = nxt(m_head);
        if (f) begin
            m_tail = m_head; m_cnt = 1;
        end else begin
            if (acc) begin m_tail = nxt(m_tail); m_cw[m_tail] = cw; end
            m_cnt = m_cnt + int'(acc) - int'(ret);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_valid = 0; rt_valid = 0; flush = 0; wr_cw = '0; ex_tag = '0;
        for (int i = 0; i < 4; i++) m_cw[i] = 16'h037F;
        m_head = 0; m_tail = 0; m_cnt = 1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cur_tag", 16'(cur_tag), 16'd0);
        check("R1 cmt_tag", 16'(cmt_tag), 16'd0);
        check("R1 cur_cw", cur_cw, 16'h037F);
        check("R1 rc", 16'(ex_rc[1:0]), 16'(RC_NEAREST));
        check("R1 stall", 16'(wr_stall), 16'd0);
        // R2 switch to truncate, back to nearest, then toward minus infinity
        step("R2", 1, 16'h0F7F, 0, 0, 0, 0);
        step("R2", 1, 16'h037F, 0, 0, 1, 0);
        step("R2", 1, 16'h077F, 0, 0, 2, 1);
        // R3 four live: next write stalls
        step("R3", 1, 16'h0B7F, 0, 0, 3, 1);
        // R8 retire and write together while full
        step("R8", 1, 16'h0B7F, 1, 0, 3, 0);
        step("R8", 1, 16'h0B7F, 0, 0, 1, 2);
        // R7 flush with a write and a retire in the same cycle
        step("R7", 1, 16'h0F7F, 1, 1, 0, 1);
        step("R7", 0, 16'h0, 0, 0, 2, 3);
        // R6 retire with one live version
        step("R6", 0, 16'h0, 1, 0, 2, 2);
        step("R6", 0, 16'h0, 0, 0, 2, 2);
        // R9 random mix through many wrap-arounds
        for (int n = 0; n < 600; n++) begin
            step("R9", ($urandom % 2) == 0, 16'($urandom), ($urandom % 3) == 0,
                 ($urandom % 20) == 0, 2'($urandom), 2'($urandom));
        end
        step("R9", 0, 16'h0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule